// File: doc/BRIEF.md
# Dual-Rate LED Dimming Engine

The engine drives sixteen open-drain LED outputs. It has two dimming channels that run independently. Each channel has an 8-bit rate value and an 8-bit duty value. Its 8-bit step counter advances once every `rate+1` pulses of a step-enable input, so one waveform period lasts 256 steps. The channel's dim signal is active while the step count is below the duty value.

Each LED has a 2-bit mode code held in one of four selector bytes. The code picks between a released pin, a pin driven low, the first channel's waveform or the second channel's waveform.

Configuration arrives over a simple byte-write port. A new rate or duty value is held back and only takes effect when that channel's step counter wraps. Separately, the level on each pad is registered and returned as a 16-bit readback, so pins left released can serve as general-purpose inputs.

Top module: `led_dim_engine`

## Requirements
- R1: While `rstN` is low, and after it rises, every selector code is 00 and `driveLow` is all zero. The defaults are rate 0 and duty 0x80 on both channels, so an LED switched to a dim mode after reset is on for 128 of every 256 steps.
- R2: With a pulse on `stepTick` in every cycle, a channel with rate value r has a period of 256·(r+1) cycles. An LED following that channel with duty value d is on (`driveLow`=1) for exactly d·(r+1) of those cycles. This includes d=255.
- R3: A duty value of 0 keeps an LED that follows that channel off for the whole period.
- R4: Mode codes are: 00 releases the pin (`driveLow`=0), 01 drives it low (`driveLow`=1), 10 follows channel 0, and 11 follows channel 1.
- R5: The write addresses are: 0 = channel 0 rate, 1 = channel 0 duty, 2 = channel 1 rate, 3 = channel 1 duty, 4+g = selector byte g. Selector byte g covers LEDs 4g..4g+3, and LED 4g+n uses bits [2n+1:2n].
- R6: A rate or duty write takes effect only when that channel's step counter wraps from 255 to 0. The rest of the current period runs on the old values.
- R7: The step counter and its prescaler advance only in cycles where `stepTick` is high. With `stepTick` held low, every dimmed output holds its level.
- R8: `levelRead` equals `padSense` as sampled at the previous clock edge, with bit i for pin i.
- R9: Taking `rstN` low in the middle of operation restores every register to its reset default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stepTick | input | 1 | Step-enable pulse for both prescalers |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| padSense | input | 16 | Sensed pad levels |
| driveLow | output | 16 | Per-LED drive-low enable (1 = LED on) |
| levelRead | output | 16 | Registered pad levels |

## Verification
The bench builds the engine with its default sizing: sixteen LEDs, four selector bytes and 8-bit rate and duty values. It pulses `stepTick` in every cycle, so one step takes `rate+1` clock cycles. Rate values are kept between 0 and 3. At those rates a whole period is at most 1024 cycles, so the bench can count on-cycles over complete periods and compare them exactly with duty·(rate+1). The same setting makes it cheap to watch a wrap, which is how the deferred update is checked.

// File: rtl/led_dim_pkg.sv
package led_dim_pkg;
  localparam int LED_COUNT   = 16;
  localparam int CH_COUNT    = 2;
  localparam int VAL_W       = 8;
  localparam int LEDS_PER_GRP = 4;
  localparam int GROUP_COUNT = LED_COUNT / LEDS_PER_GRP;
  localparam int REG_COUNT   = 2 * CH_COUNT + GROUP_COUNT;
  localparam int ADDR_W      = $clog2(REG_COUNT);

  typedef struct packed {
    logic [CH_COUNT-1:0]    rateWr;
    logic [CH_COUNT-1:0]    dutyWr;
    logic [GROUP_COUNT-1:0] selWr;
  } dimStrobes_t;
endpackage

// File: rtl/dim_channel.sv
module dim_channel #(
  parameter int VAL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             rateWr,
  input  logic             dutyWr,
  input  logic [VAL_W-1:0] wrData,
  output logic             dimOn
);
  localparam logic [VAL_W-1:0] DUTY_RST = VAL_W'(1) << (VAL_W - 1);

  logic [VAL_W-1:0] ratePend, dutyPend, rateAct, dutyAct;
  logic [VAL_W-1:0] preCnt, stepCnt;
  logic stepAdv, wrap;

  assign stepAdv = tick && (preCnt == rateAct);
  assign wrap    = stepAdv && (stepCnt == '1);
  assign dimOn   = stepCnt < dutyAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ratePend <= '0;
      dutyPend <= DUTY_RST;
    end else begin
      if (rateWr) ratePend <= wrData;
      if (dutyWr) dutyPend <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateAct <= '0;
      dutyAct <= DUTY_RST;
      preCnt  <= '0;
      stepCnt <= '0;
    end else if (tick) begin
      if (stepAdv) begin
        preCnt  <= '0;
        stepCnt <= stepCnt + 1'b1;
        if (wrap) begin
          rateAct <= ratePend;
          dutyAct <= dutyPend;
        end
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  assert_hold_no_tick_R7: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(stepCnt) && $stable(preCnt));

  assert_duty_at_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    !wrap |=> $stable(dutyAct) && $stable(rateAct));

  assert_pre_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= rateAct);
endmodule

// File: rtl/led_dim_ctrl.sv
module led_dim_ctrl
  import led_dim_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output dimStrobes_t       strobes
);
  always_comb begin
    strobes = '0;
    for (int c = 0; c < CH_COUNT; c++) begin
      strobes.rateWr[c] = wrEn && (wrAddr == ADDR_W'(2 * c));
      strobes.dutyWr[c] = wrEn && (wrAddr == ADDR_W'(2 * c + 1));
    end
    for (int g = 0; g < GROUP_COUNT; g++)
      strobes.selWr[g] = wrEn && (wrAddr == ADDR_W'(2 * CH_COUNT + g));
  end

  assert_single_target_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.rateWr, strobes.dutyWr, strobes.selWr}));
endmodule

// File: rtl/led_dim_datapath.sv
module led_dim_datapath
  import led_dim_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 stepTick,
  input  dimStrobes_t          strobes,
  input  logic [VAL_W-1:0]     wrData,
  input  logic [LED_COUNT-1:0] padSense,
  output logic [LED_COUNT-1:0] driveLow,
  output logic [LED_COUNT-1:0] levelRead
);
  localparam int SEL_W = 2 * LED_COUNT;

  logic [CH_COUNT-1:0] dimOn;
  logic [SEL_W-1:0]    selVec;

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
    dim_channel #(.VAL_W(VAL_W)) u_ch (
      .clk    (clk),
      .rstN   (rstN),
      .tick   (stepTick),
      .rateWr (strobes.rateWr[c]),
      .dutyWr (strobes.dutyWr[c]),
      .wrData (wrData),
      .dimOn  (dimOn[c])
    );
  end

  for (genvar g = 0; g < GROUP_COUNT; g++) begin : g_sel
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) selVec[2*LEDS_PER_GRP*g +: 2*LEDS_PER_GRP] <= '0;
      else if (strobes.selWr[g])
        selVec[2*LEDS_PER_GRP*g +: 2*LEDS_PER_GRP] <= wrData;
    end
  end

  for (genvar i = 0; i < LED_COUNT; i++) begin : g_led
    always_comb begin
      unique case (selVec[2*i +: 2])
        2'b00:   driveLow[i] = 1'b0;
        2'b01:   driveLow[i] = 1'b1;
        2'b10:   driveLow[i] = dimOn[0];
        default: driveLow[i] = dimOn[1];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) levelRead <= '0;
    else       levelRead <= padSense;
  end

  assert_reset_dark_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> driveLow == '0);

  assert_readback_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> levelRead == $past(padSense));
endmodule

// File: rtl/led_dim_engine.sv
module led_dim_engine
  import led_dim_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 stepTick,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [VAL_W-1:0]     wrData,
  input  logic [LED_COUNT-1:0] padSense,
  output logic [LED_COUNT-1:0] driveLow,
  output logic [LED_COUNT-1:0] levelRead
);
  dimStrobes_t strobes;

  led_dim_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .strobes (strobes)
  );

  led_dim_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stepTick  (stepTick),
    .strobes   (strobes),
    .wrData    (wrData),
    .padSense  (padSense),
    .driveLow  (driveLow),
    .levelRead (levelRead)
  );
endmodule

// File: tb/sim_led_dim_engine.sv
`timescale 1ns/1ps
module sim_led_dim_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stepTick = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [15:0] padSense = '0;
  logic [15:0] driveLow, levelRead;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  led_dim_engine u0 (
    .clk(clk), .rstN(rstN), .stepTick(stepTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .padSense(padSense),
    .driveLow(driveLow), .levelRead(levelRead)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    wrEn = 1'b1; wrAddr = 3'(addr); wrData = 8'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic settle();
    repeat (2100) @(negedge clk);
  endtask

  task automatic measure(input int led, input int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (driveLow[led]) cnt++;
    end
  endtask

  task automatic do_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(driveLow == 16'h0, "R1 dark during reset", driveLow, 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check(driveLow == 16'h0, "R1 dark after reset", driveLow, 0);
  endtask

  task automatic t_defaults();
    int cnt;
    wr(4, 8'b0000_1110);       // LED0 -> 10, LED1 -> 11
    measure(0, 256, cnt);
    check(cnt == 128, "R1 default duty ch0", cnt, 128);
    measure(1, 256, cnt);
    check(cnt == 128, "R1 default duty ch1", cnt, 128);
  endtask

  task automatic t_modes();
    int cnt;
    wr(3, 64);
    wr(5, 8'hE4);              // LED7:11 LED6:10 LED5:01 LED4:00
    settle();
    measure(4, 256, cnt); check(cnt == 0,   "R4 code 00", cnt, 0);
    measure(5, 256, cnt); check(cnt == 256, "R4 code 01", cnt, 256);
    measure(6, 256, cnt); check(cnt == 128, "R4 code 10", cnt, 128);
    measure(7, 256, cnt); check(cnt == 64,  "R4 code 11", cnt, 64);
  endtask

  task automatic t_mapping();
    wr(7, 8'h40);              // LED15 on
    wr(6, 8'h01);              // LED8 on
    @(negedge clk);
    check(driveLow[15:12] == 4'b1000, "R5 group3 slot3", driveLow[15:12], 8);
    check(driveLow[11:8] == 4'b0001, "R5 group2 slot0", driveLow[11:8], 1);
  endtask

  task automatic t_rate();
    int cnt;
    wr(4, 8'h02);              // LED0 -> ch0
    wr(6, 8'h03);              // LED8 -> ch1
    wr(0, 3); wr(1, 32);
    wr(2, 1); wr(3, 255);
    settle();
    measure(0, 1024, cnt); check(cnt == 128, "R2 rate3 duty32", cnt, 128);
    measure(8, 512, cnt);  check(cnt == 510, "R2 rate1 duty255", cnt, 510);
  endtask

  task automatic t_zero();
    int cnt;
    wr(1, 0);
    settle();
    measure(0, 1024, cnt); check(cnt == 0, "R3 duty zero", cnt, 0);
  endtask

  task automatic t_midreset();
    int cnt;
    do_reset();
    check(driveLow == 16'h0, "R9 selectors cleared", driveLow, 0);
    wr(4, 8'h02);
    measure(0, 256, cnt);
    check(cnt == 128, "R9 ch0 back to defaults", cnt, 128);
  endtask

  task automatic t_tick();
    logic first;
    int moved = 0;
    stepTick = 1'b0;
    @(negedge clk);
    first = driveLow[0];
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (driveLow[0] != first) moved++;
    end
    check(moved == 0, "R7 frozen without tick", moved, 0);
    stepTick = 1'b1;
  endtask

  task automatic t_defer();
    int cnt;
    int held = 0;
    bit found = 0;
    logic prev = driveLow[0];
    for (int k = 0; k < 600 && !found; k++) begin
      @(negedge clk);
      if (!prev && driveLow[0]) found = 1;
      prev = driveLow[0];
    end
    check(found, "R6 wrap seen", found, 1);
    wr(1, 0);                  // step now 1, old duty 128 still active
    for (int k = 0; k < 100; k++) begin
      if (driveLow[0]) held++;
      @(negedge clk);
    end
    check(held == 100, "R6 old duty until wrap", held, 100);
    repeat (400) @(negedge clk);
    measure(0, 256, cnt);
    check(cnt == 0, "R6 new duty after wrap", cnt, 0);
  endtask

  task automatic t_readback();
    padSense = 16'hA5C3;
    @(negedge clk);
    check(levelRead == 16'hA5C3, "R8 readback A5C3", levelRead, 16'hA5C3);
    padSense = 16'h0001;
    @(negedge clk);
    check(levelRead == 16'h0001, "R8 readback bit0", levelRead, 1);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_defaults();
    t_modes();
    t_mapping();
    t_rate();
    t_zero();
    t_midreset();
    t_tick();
    t_defer();
    t_readback();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule